// File: doc/BRIEF.md
# Word-to-Byte Register Bus Adapter

This block sits between a 32-bit, word-addressed memory-mapped slave port and a bank of eight 8-bit peripheral registers. The port carries per-byte lane enables, so a byte-wide access from the master reaches the block as a word access with one enable bit set. The adapter does not use address bits below the word boundary. It turns the single active lane into the low two bits of a register index. The one word-address bit supplies the top bit.

On a write, only the byte on the selected lane is stored, and only into the register it addresses. A byte write therefore never disturbs the other registers in the same word. On a read, the selected register's byte comes back on the same lane, with every other lane driven to zero. A master that always issues full-word reads still works: the all-lanes pattern decodes to lane 0. Some offsets have different meanings for reads and writes. At those offsets a read returns receive data or status from the peripheral, and a write loads transmit data or a one-shot command. The adapter exposes the stored configuration to the peripheral logic that sits behind it.

Top module: `byte_lane_reg_bridge`

## Requirements
- R1: While `rst` is high at a clock edge, `presc_o`, `ctrl_o`, `txd_o`, `cmd_o` and `bus_rdata` are cleared to zero.
- R2: The register index is {`bus_addr`, lane}. `bus_be` 4'b0001 selects lane 0 (data[7:0]), 4'b0010 selects lane 1 (data[15:8]), 4'b0100 selects lane 2 (data[23:16]) and 4'b1000 selects lane 3 (data[31:24]). A write stores the byte taken from the selected lane.
- R3: Any `bus_be` pattern that is not one-hot, including 4'b0000 and 4'b1111, selects lane 0 of the addressed word.
- R4: A write happens only when `bus_wr` is 1 and `bus_rd` is 0. When both are 1, no register changes and `bus_rdata` holds.
- R5: An accepted write changes only the register at its index. Writes to indices 5, 6 and 7 change nothing.
- R6: Write map: index 0 loads `presc_o[7:0]`, index 1 loads `presc_o[15:8]`, index 2 loads `ctrl_o`, index 3 loads `txd_o` and index 4 loads `cmd_o`.
- R7: Read map: index 0 returns `presc_o[7:0]` and index 1 returns `presc_o[15:8]`. Index 2 returns `ctrl_o`, index 3 returns `rxd_i` and index 4 returns `stat_i`. Index 5 returns `txd_o`, index 6 returns `cmd_o` and index 7 returns zero. All values are those present in the read cycle.
- R8: A read happens when `bus_rd` is 1 and `bus_wr` is 0. On the next clock edge `bus_rdata` takes the selected byte on the selected lane, with all other lanes zero. Without a read, `bus_rdata` holds.
- R9: `cmd_o` holds a written command for exactly one cycle after the write edge. It returns to zero at the next edge unless that edge writes the command again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Word address bit (upper bit of register index) |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| rxd_i | input | 8 | Receive data from the peripheral |
| stat_i | input | 8 | Status from the peripheral |
| presc_o | output | 16 | Clock prescale value |
| ctrl_o | output | 8 | Control register |
| txd_o | output | 8 | Transmit data register |
| cmd_o | output | 8 | One-shot command register |

## Verification
The assertions check the following on every cycle:
- the single-cycle life of the command;
- that registers stay unchanged when no write is accepted, or when both strobes collide;
- that the transmit register is isolated from writes to other indices;
- that read data never occupies more than one lane and holds between reads;
- that non-one-hot enables fall back to lane 0.

The bench scenarios are what show that each index reaches the right register, including the split read/write meanings at indices 3 and 4. They also show that the byte comes from the right lane and that reserved and read-only indices ignore writes. Finally, they show that full-word and empty enable patterns resolve to lane 0 with the exact values the reference model predicts.

// File: rtl/blrb_pkg.sv
package blrb_pkg;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_REG_W  = 8;
  localparam int DEF_ADDR_W = 1;

  // register index map (writes / reads)
  localparam int OFF_PRESC_LO = 0;
  localparam int OFF_PRESC_HI = 1;
  localparam int OFF_CTRL     = 2;
  localparam int OFF_TX_RX    = 3;  // write: transmit, read: receive
  localparam int OFF_CMD_STAT = 4;  // write: command, read: status
  localparam int OFF_TX_VIEW  = 5;
  localparam int OFF_CMD_VIEW = 6;
  localparam int OFF_RSVD     = 7;
endpackage

// File: rtl/blrb_lane_decode.sv
module blrb_lane_decode #(
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  be,
  output logic [LANE_W-1:0] lane
);
  int unsigned hits;
  logic [LANE_W-1:0] pick;

  always_comb begin
    hits = 0;
    pick = '0;
    for (int i = 0; i < LANES; i++) begin
      if (be[i]) begin
        hits = hits + 1;
        pick = LANE_W'(i);
      end
    end
    lane = (hits == 1) ? pick : '0;
  end

  AST_NONONEHOT_LANE0: assert property (@(posedge clk) disable iff (rst)
    ($countones(be) != 1) |-> (lane == '0)); // R3
endmodule

// File: rtl/blrb_reg_bank.sv
module blrb_reg_bank
  import blrb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  parameter int IDX_W  = 3,
  parameter int LANE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [LANE_W-1:0]  lane,
  input  logic [DATA_W-1:0]  wdata,
  output logic [2*REG_W-1:0] presc_q,
  output logic [REG_W-1:0]   ctrl_q,
  output logic [REG_W-1:0]   txd_q,
  output logic [REG_W-1:0]   cmd_q
);
  logic [REG_W-1:0] wr_byte;
  assign wr_byte = wdata[lane*REG_W +: REG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      ctrl_q  <= '0;
      txd_q   <= '0;
      cmd_q   <= '0;
    end else begin
      cmd_q <= '0;
      if (we) begin
        if (idx == IDX_W'(OFF_PRESC_LO)) presc_q[REG_W-1:0]       <= wr_byte;
        if (idx == IDX_W'(OFF_PRESC_HI)) presc_q[2*REG_W-1:REG_W] <= wr_byte;
        if (idx == IDX_W'(OFF_CTRL))     ctrl_q                   <= wr_byte;
        if (idx == IDX_W'(OFF_TX_RX))    txd_q                    <= wr_byte;
        if (idx == IDX_W'(OFF_CMD_STAT)) cmd_q                    <= wr_byte;
      end
    end
  end

  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(we && idx == IDX_W'(OFF_CMD_STAT)) |=> (cmd_q == '0)); // R9
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable({presc_q, ctrl_q, txd_q})); // R4
  AST_TX_ONLY_OWN: assert property (@(posedge clk) disable iff (rst)
    (we && idx != IDX_W'(OFF_TX_RX)) |=> $stable(txd_q)); // R5
endmodule

// File: rtl/blrb_read_port.sv
module blrb_read_port
  import blrb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  parameter int IDX_W  = 3,
  parameter int LANE_W = 2,
  parameter int LANES  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               re,
  input  logic [IDX_W-1:0]   idx,
  input  logic [LANE_W-1:0]  lane,
  input  logic [2*REG_W-1:0] presc,
  input  logic [REG_W-1:0]   ctrl,
  input  logic [REG_W-1:0]   txd,
  input  logic [REG_W-1:0]   cmd,
  input  logic [REG_W-1:0]   rxd,
  input  logic [REG_W-1:0]   stat,
  output logic [DATA_W-1:0]  rdata_q
);
  logic [REG_W-1:0] rd_byte;

  always_comb begin
    case (int'(idx))
      OFF_PRESC_LO: rd_byte = presc[REG_W-1:0];
      OFF_PRESC_HI: rd_byte = presc[2*REG_W-1:REG_W];
      OFF_CTRL:     rd_byte = ctrl;
      OFF_TX_RX:    rd_byte = rxd;
      OFF_CMD_STAT: rd_byte = stat;
      OFF_TX_VIEW:  rd_byte = txd;
      OFF_CMD_VIEW: rd_byte = cmd;
      default:      rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (re) begin
      for (int i = 0; i < LANES; i++) begin
        rdata_q[i*REG_W +: REG_W] <= (LANE_W'(i) == lane) ? rd_byte : '0;
      end
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata_q)); // R8
endmodule

// File: rtl/byte_lane_reg_bridge.sv
module byte_lane_reg_bridge
  import blrb_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int REG_W  = DEF_REG_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W/REG_W-1:0]   bus_be,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [REG_W-1:0]          rxd_i,
  input  logic [REG_W-1:0]          stat_i,
  output logic [2*REG_W-1:0]        presc_o,
  output logic [REG_W-1:0]          ctrl_o,
  output logic [REG_W-1:0]          txd_o,
  output logic [REG_W-1:0]          cmd_o
);
  localparam int LANES  = DATA_W / REG_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int IDX_W  = ADDR_W + LANE_W;

  logic [LANE_W-1:0] lane;
  logic [IDX_W-1:0]  idx;
  logic              wr_acc, rd_acc;

  assign idx    = {bus_addr, lane};
  assign wr_acc = bus_wr & ~bus_rd;
  assign rd_acc = bus_rd & ~bus_wr;

  blrb_lane_decode #(.LANES(LANES), .LANE_W(LANE_W)) u_dec (
    .clk(clk), .rst(rst), .be(bus_be), .lane(lane)
  );

  blrb_reg_bank #(.DATA_W(DATA_W), .REG_W(REG_W), .IDX_W(IDX_W), .LANE_W(LANE_W)) u_bank (
    .clk(clk), .rst(rst), .we(wr_acc), .idx(idx), .lane(lane), .wdata(bus_wdata),
    .presc_q(presc_o), .ctrl_q(ctrl_o), .txd_q(txd_o), .cmd_q(cmd_o)
  );

  blrb_read_port #(.DATA_W(DATA_W), .REG_W(REG_W), .IDX_W(IDX_W), .LANE_W(LANE_W),
                   .LANES(LANES)) u_rd (
    .clk(clk), .rst(rst), .re(rd_acc), .idx(idx), .lane(lane),
    .presc(presc_o), .ctrl(ctrl_o), .txd(txd_o), .cmd(cmd_o),
    .rxd(rxd_i), .stat(stat_i), .rdata_q(bus_rdata)
  );

  logic [LANES-1:0] lane_used;
  always_comb begin
    for (int i = 0; i < LANES; i++) lane_used[i] = |bus_rdata[i*REG_W +: REG_W];
  end

  AST_RDATA_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_used)); // R8
  AST_COLLISION_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_rd) |=> $stable({presc_o, ctrl_o, txd_o, bus_rdata})); // R4
endmodule

// File: tb/tb_byte_lane_reg_bridge.sv
module tb_byte_lane_reg_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [0:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  rxd_i = 8'h00, stat_i = 8'h00;
  logic [15:0] presc_o;
  logic [7:0]  ctrl_o, txd_o, cmd_o;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  byte_lane_reg_bridge dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .rxd_i(rxd_i), .stat_i(stat_i),
    .presc_o(presc_o), .ctrl_o(ctrl_o), .txd_o(txd_o), .cmd_o(cmd_o)
  );

  // behavioural reference state
  int unsigned m_presc = 0, m_ctrl = 0, m_tx = 0, m_cmd = 0;
  logic [31:0] m_rdata = '0;

  always @(posedge clk) begin
    int ln, ones, ix, rb, nxt_cmd;
    if (rst) begin
      m_presc = 0; m_ctrl = 0; m_tx = 0; m_cmd = 0; m_rdata = '0;
    end else begin
      ones = 0; ln = 0;
      for (int i = 0; i < 4; i++) if (bus_be[i]) begin ones++; ln = i; end
      if (ones != 1) ln = 0;
      ix = bus_addr * 4 + ln;
      nxt_cmd = 0;
      if (bus_rd && !bus_wr) begin
        case (ix)
          0: rb = m_presc % 256;
          1: rb = m_presc / 256;
          2: rb = m_ctrl;
          3: rb = rxd_i;
          4: rb = stat_i;
          5: rb = m_tx;
          6: rb = m_cmd;
          default: rb = 0;
        endcase
        m_rdata = 32'(rb) << (8 * ln);
      end
      if (bus_wr && !bus_rd) begin
        rb = (bus_wdata >> (8 * ln)) & 32'hFF;
        case (ix)
          0: m_presc = (m_presc & 32'hFF00) | rb;
          1: m_presc = (m_presc & 32'h00FF) | (rb * 256);
          2: m_ctrl = rb;
          3: m_tx = rb;
          4: nxt_cmd = rb;
          default: ;
        endcase
      end
      m_cmd = nxt_cmd;
    end
  end

  task automatic chk(string what, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    chk("presc R6", presc_o, m_presc);
    chk("ctrl R6", ctrl_o, m_ctrl);
    chk("txd R5", txd_o, m_tx);
    chk("cmd R9", cmd_o, m_cmd);
    chk("rdata R8", bus_rdata, m_rdata);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic op(bit a, logic [3:0] be, logic [31:0] wd, bit w, bit r);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = wd; bus_wr = w; bus_rd = r;
  endtask

  task automatic idle();
    op(0, 4'b0000, 32'h0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rxd_i = 8'h5A; stat_i = 8'hC3;

    cur_req = "R6";  // write each writable index through its own lane
    for (int k = 0; k < 5; k++) op(k[2], 4'b0001 << k[1:0], 32'h44332211 + 32'h01010101 * k, 1, 0);
    idle();

    cur_req = "R7";  // read every index back, lane placement checked by R8 compare
    for (int k = 0; k < 8; k++) op(k[2], 4'b0001 << k[1:0], 32'hFFFFFFFF, 0, 1);
    idle();

    cur_req = "R2";  // byte taken from upper lane goes to index 3
    op(0, 4'b1000, 32'hE7000000, 1, 0);
    op(1, 4'b0010, 32'h0, 0, 1);   // read txd view (index 5) on lane 1
    idle();

    cur_req = "R3";  // non-one-hot patterns fall back to lane 0
    op(0, 4'b1111, 32'hAABBCC9D, 1, 0);
    op(0, 4'b0000, 32'h11223344, 1, 0);
    op(0, 4'b0110, 32'h55667788, 1, 0);
    op(1, 4'b1100, 32'h000000F1, 1, 0);
    op(0, 4'b1111, 32'h0, 0, 1);
    op(1, 4'b1111, 32'h0, 0, 1);
    idle();

    cur_req = "R4";  // colliding strobes: no write, read data held
    op(0, 4'b0100, 32'h00990000, 1, 1);
    op(1, 4'b0001, 32'h000000EE, 1, 1);
    idle();

    cur_req = "R5";  // writes to read-only / reserved indices ignored
    op(1, 4'b0010, 32'h0000DD00, 1, 0);
    op(1, 4'b0100, 32'h00CC0000, 1, 0);
    op(1, 4'b1000, 32'hBB000000, 1, 0);
    op(1, 4'b1000, 32'h0, 0, 1);
    idle();

    cur_req = "R9";  // command pulse, back-to-back, then read view
    op(1, 4'b0001, 32'h00000081, 1, 0);
    idle();
    op(1, 4'b0001, 32'h00000003, 1, 0);
    op(1, 4'b0001, 32'h00000004, 1, 0);
    op(1, 4'b0100, 32'h0, 0, 1);
    idle();

    cur_req = "R8";  // mixed traffic with moving peripheral inputs
    for (int k = 0; k < 64; k++) begin
      rxd_i = 8'(k * 7); stat_i = 8'(k * 13 + 1);
      op(k[3], 4'b0001 << k[1:0], 32'h9E3779B9 * (k + 1), k[2], !k[2] || k[5]);
    end
    idle();

    cur_req = "R1";  // reset clears everything
    op(0, 4'b0001, 32'h0, 0, 1);
    rst = 1'b1;
    idle(); idle();
    @(negedge clk);
    chk("presc after reset", presc_o, 0);
    chk("rdata after reset", bus_rdata, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule